// File: doc/BRIEF.md
# Vectored priority interrupt controller

This block collects level-sensitive interrupt requests from a set of devices plus one non-maskable source. It picks the highest-priority request that is allowed to interrupt, and raises a single interrupt line to the processor. The processor accepts the interrupt at an instruction boundary by asserting an acknowledge. In that same cycle the controller drives the winning vector number onto a vector bus. From the next cycle on it presents the address of the matching vector-table entry, which is a programmable base plus four times the vector.

Each source has an in-service bit. The bit is set when its interrupt is accepted. An explicit end-of-service strobe from the processor clears the highest-priority bit that is set. A pending request may interrupt only when its priority is strictly higher than every source that is in service, so higher-priority requests nest over lower-priority handlers. A global enable input blocks the maskable sources. The non-maskable source ignores that enable and always outranks every other source.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, int_o is 0, vec_o is 0, and tbl_addr_o equals tbl_base_i (the latched vector resets to 0).
- R2: Priority is fixed and the lowest source index wins. Source 0 is nmi_i and has vector 0. Source k+1 is irq_i[k] and has vector k+1.
- R3: Requests are registered once before arbitration. int_o first reflects a new request in the cycle after the clock edge that samples it, and not before that edge.
- R4: An interrupt is accepted only when boundary_i and ack_i are both high while int_o is high. Acknowledge without the boundary strobe changes neither the in-service state nor tbl_addr_o.
- R5: vec_o carries the winning vector during an accepting cycle and is 0 in every other cycle.
- R6: From the cycle after an accept, tbl_addr_o equals tbl_base_i + 4 × the accepted vector. For example, vector 5 with base 0 gives 0x14.
- R7: While gie_i is 0, maskable requests do not raise int_o and cannot be accepted.
- R8: nmi_i raises int_o and is accepted as vector 0 regardless of gie_i, and it wins over any maskable request.
- R9: A pending request raises int_o only if its index is strictly lower than the index of every source that is in service. Requests of equal or lower priority wait.
- R10: A higher-priority request that arrives while a lower-priority source is in service raises int_o again and can be accepted, so that service nests.
- R11: A pulse on eos_i clears only the highest-priority in-service bit. A waiting lower-priority request then interrupts once nothing of higher priority stays in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable request, level |
| irq_i | input | N_SRC | Maskable requests, level; bit k is source k+1 |
| gie_i | input | 1 | Global enable for the maskable sources |
| tbl_base_i | input | ADDR_W | Base address of the vector table |
| boundary_i | input | 1 | Instruction-boundary strobe from the processor |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| eos_i | input | 1 | End-of-service strobe |
| int_o | output | 1 | Interrupt line to the processor |
| vec_o | output | IDX_W | Vector number; driven only in an accepting cycle |
| tbl_addr_o | output | ADDR_W | Vector-table entry address for the last accepted vector |

## Verification
The assertions check four properties on every cycle. First, vec_o stays zero outside acknowledged boundaries. Second, the table address follows the vector accepted one cycle earlier. Third, the in-service set gains exactly one bit on an accept, loses exactly one bit on end-of-service, and holds otherwise. Fourth, a masked controller raises the line only for a registered non-maskable request. Several behaviours are shown only by the bench scenarios: which source wins among simultaneous requests, the one-cycle registration delay, the strict-priority blocking by in-service sources, nesting three levels deep, and the order in which waiting requests resume after end-of-service.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  // each vector-table entry holds a 4-byte address
  localparam int unsigned ENTRY_SHIFT = 2;
endpackage

// File: rtl/prio_req_reg.sv
module prio_req_reg #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/prio_lead.sv
// Finds the lowest set index (highest priority).
module prio_lead #(
  parameter int unsigned W  = 9,
  parameter int unsigned IW = 4
) (
  input  logic [W-1:0]  bits_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (bits_i[k]) begin
        found_o = 1'b1;
        idx_o   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned N_TOT = N_SRC + 1,
  localparam int unsigned IDX_W = $clog2(N_TOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_i,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic              gie_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic              boundary_i,
  input  logic              ack_i,
  input  logic              eos_i,
  output logic              int_o,
  output logic [IDX_W-1:0]  vec_o,
  output logic [ADDR_W-1:0] tbl_addr_o
);
  import prio_intc_pkg::*;

  logic [N_TOT-1:0] req_q;
  logic [N_TOT-1:0] isr_q, isr_d, isr_set, isr_clr;
  logic [N_TOT-1:0] elig;
  logic             isr_any, win_any, accept;
  logic [IDX_W-1:0] isr_idx, win_idx, cur_vec_q;

  prio_req_reg #(.W(N_TOT)) i_req (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({irq_i, nmi_i}),
    .q_o   (req_q)
  );

  prio_lead #(.W(N_TOT), .IW(IDX_W)) i_isr_lead (
    .bits_i (isr_q),
    .found_o(isr_any),
    .idx_o  (isr_idx)
  );

  // source 0 bypasses the enable; all need strictly higher priority than in-service
  for (genvar k = 0; k < N_TOT; k++) begin : g_elig
    logic en_ok, prio_ok;
    if (k == 0) begin : g_nmi
      assign en_ok = 1'b1;
    end else begin : g_mask
      assign en_ok = gie_i;
    end
    assign prio_ok = !isr_any || (IDX_W'(k) < isr_idx);
    assign elig[k] = req_q[k] & en_ok & prio_ok;
  end

  prio_lead #(.W(N_TOT), .IW(IDX_W)) i_win_lead (
    .bits_i (elig),
    .found_o(win_any),
    .idx_o  (win_idx)
  );

  assign accept = boundary_i & ack_i & win_any;
  assign int_o  = win_any;
  assign vec_o  = accept ? win_idx : '0;

  always_comb begin
    isr_set = '0;
    isr_clr = '0;
    if (accept)            isr_set[win_idx] = 1'b1;
    if (eos_i && isr_any)  isr_clr[isr_idx] = 1'b1;
    isr_d = (isr_q & ~isr_clr) | isr_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q     <= '0;
      cur_vec_q <= '0;
    end else begin
      isr_q <= isr_d;
      if (accept) cur_vec_q <= win_idx;
    end
  end

  assign tbl_addr_o = tbl_base_i + (ADDR_W'(cur_vec_q) << ENTRY_SHIFT);
endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk #(
  parameter int unsigned N_TOT  = 9,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              nmi_i,
  input logic              gie_i,
  input logic              boundary_i,
  input logic              ack_i,
  input logic              eos_i,
  input logic              int_o,
  input logic [IDX_W-1:0]  vec_o,
  input logic [ADDR_W-1:0] tbl_base_i,
  input logic [ADDR_W-1:0] tbl_addr_o,
  input logic [N_TOT-1:0]  isr_i
);
  logic acc;
  assign acc = boundary_i && ack_i && int_o;

  assert_vec_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(boundary_i && ack_i) |-> vec_o == '0);

  assert_tbl_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(acc) |-> tbl_addr_o == tbl_base_i + (ADDR_W'($past(vec_o)) << 2));

  assert_no_ack_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(boundary_i && ack_i) && !eos_i) |=> $stable(isr_i));

  assert_accept_adds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !eos_i) |=> $countones(isr_i) == $countones($past(isr_i)) + 1);

  assert_eos_clears_one_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_i && !acc && isr_i != '0) |=> $countones(isr_i) + 1 == $countones($past(isr_i)));

  assert_mask_nmi_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_o && !gie_i) |-> $past(nmi_i));
endmodule

bind prio_vec_intc prio_vec_intc_chk #(
  .N_TOT (N_TOT),
  .IDX_W (IDX_W),
  .ADDR_W(ADDR_W)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .nmi_i     (nmi_i),
  .gie_i     (gie_i),
  .boundary_i(boundary_i),
  .ack_i     (ack_i),
  .eos_i     (eos_i),
  .int_o     (int_o),
  .vec_o     (vec_o),
  .tbl_base_i(tbl_base_i),
  .tbl_addr_o(tbl_addr_o),
  .isr_i     (isr_q)
);

// File: tb/test_prio_vec_intc.sv
`timescale 1ns/1ps
module test_prio_vec_intc;
  localparam int unsigned N_SRC  = 8;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned IDX_W  = $clog2(N_SRC + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              nmi = 1'b0;
  logic [N_SRC-1:0]  irq = '0;
  logic              gie = 1'b0;
  logic [ADDR_W-1:0] base = 16'h0100;
  logic              bnd = 1'b0, ack = 1'b0, eos = 1'b0;
  logic              int_l;
  logic [IDX_W-1:0]  vec;
  logic [ADDR_W-1:0] taddr;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_vec_intc #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) i_prio_vec_intc (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .irq_i(irq), .gie_i(gie),
    .tbl_base_i(base), .boundary_i(bnd), .ack_i(ack), .eos_i(eos),
    .int_o(int_l), .vec_o(vec), .tbl_addr_o(taddr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // accept with boundary+ack; checks vector during the cycle and table address after
  task automatic take(input int exp_vec, input string tag);
    bnd = 1'b1; ack = 1'b1;
    #1;
    chk({tag, " R5 vec on accept"}, 32'(vec), 32'(exp_vec));
    tick();
    bnd = 1'b0; ack = 1'b0;
    #1;
    chk({tag, " R6 table addr"}, 32'(taddr), 32'(base) + 32'(exp_vec) * 4);
    chk({tag, " R5 vec idle"}, 32'(vec), 0);
  endtask

  task automatic end_svc();
    eos = 1'b1;
    tick();
    eos = 1'b0;
    #1;
  endtask

  task automatic drain();
    irq = '0; nmi = 1'b0;
    for (int i = 0; i <= N_SRC; i++) end_svc();
    tick();
    chk("drain int idle", 32'(int_l), 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 int after reset", 32'(int_l), 0);
    chk("R1 vec after reset", 32'(vec), 0);
    chk("R1 addr after reset", 32'(taddr), 32'(base));
  endtask

  task automatic t_priority();
    gie = 1'b1;
    irq = 8'b0010_0100;                 // sources 3 and 6
    #1;
    chk("R3 not before edge", 32'(int_l), 0);
    tick();
    chk("R3 int after edge", 32'(int_l), 1);
    ack = 1'b1;                         // no boundary strobe
    #1;
    chk("R4 ack alone no vec", 32'(vec), 0);
    tick();
    ack = 1'b0;
    #1;
    chk("R4 addr unchanged", 32'(taddr), 32'(base));
    chk("R4 still pending", 32'(int_l), 1);
    take(3, "R2 lowest wins");
    chk("R9 lower and equal blocked", 32'(int_l), 0);
    irq[2] = 1'b0;
    tick();
    end_svc();
    chk("R11 lower resumes", 32'(int_l), 1);
    take(6, "R11 second");
    drain();
  endtask

  task automatic t_mask();
    gie = 1'b0;
    irq = 8'b0000_0001;                 // source 1
    tick(); tick();
    chk("R7 masked int", 32'(int_l), 0);
    bnd = 1'b1; ack = 1'b1;
    #1;
    chk("R7 masked no vec", 32'(vec), 0);
    tick();
    bnd = 1'b0; ack = 1'b0;
    gie = 1'b1;
    #1;
    chk("R7 unmask raises", 32'(int_l), 1);
    take(1, "R7 after unmask");
    drain();
  endtask

  task automatic t_nmi();
    gie = 1'b0;
    nmi = 1'b1;
    irq = 8'b0000_0001;
    tick();
    chk("R8 nmi ignores mask", 32'(int_l), 1);
    gie = 1'b1;
    take(0, "R8 nmi wins");
    chk("R8 nmi in service blocks all", 32'(int_l), 0);
    drain();
  endtask

  task automatic t_nest();
    gie = 1'b1;
    irq = 8'b0010_0000;                 // source 6
    tick();
    take(6, "R10 first level");
    irq[6] = 1'b1;                      // source 7, lower
    tick();
    chk("R9 lower than active", 32'(int_l), 0);
    irq[1] = 1'b1;                      // source 2, higher
    tick();
    chk("R10 higher preempts", 32'(int_l), 1);
    take(2, "R10 second level");
    nmi = 1'b1;
    tick();
    take(0, "R10 third level");
    nmi = 1'b0;
    tick();
    end_svc();                          // clears source 0
    chk("R11 equal stays blocked", 32'(int_l), 0);
    irq[1] = 1'b0;
    tick();
    end_svc();                          // clears source 2
    chk("R11 only top cleared", 32'(int_l), 0);
    end_svc();                          // clears source 6
    chk("R11 source 6 resumes", 32'(int_l), 1);
    take(6, "R11 resume");
    drain();
  endtask

  task automatic t_base_zero();
    base = '0;
    irq = 8'b0001_0000;                 // source 5
    tick();
    take(5, "R6 base zero");
    chk("R6 addr is 0x14", 32'(taddr), 32'h14);
    drain();
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_priority();
    t_mask();
    t_nmi();
    t_nest();
    t_base_zero();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule